// File: doc/BRIEF.md
# Thresholded transmit packet FIFO

This block holds outgoing packets between a host that writes 32-bit words and a byte-wide transmit sink. The host frames each packet as one header word carrying the unpadded byte count in bits 15:0, followed by as many payload words as are needed to hold that count. The final word is padded up to a whole word. The block reports its free space in bytes, counting header words too. It raises an available flag when that space reaches a level set by a command. It starts sending a packet only once enough of it is buffered.

On the sink side, only the true payload bytes leave the block, lowest byte lane first, over a valid/ready pair. Each packet that finishes, and each packet the sink starves, leaves a status byte in a small queue. The host reads the oldest status byte and pops it with a strobe. If the sink starves mid-packet, the transmitter stops. It stays stopped until the host issues a transmit reset and then enables the transmitter again.

Top module: `txfifo_thresh`

## Requirements
- R1: After reset, freeBytes equals the capacity (4 x DEPTH_WORDS), txAvail is 1, txComplete is 0, txStatus is 0, macValid is 0 and the transmitter is disabled.
- R2: A packet is a header word whose bits 15:0 give the length, followed by ceil(length/4) data words. Exactly length bytes reach the sink, taken from bits 7:0, 15:8, 23:16 and 31:24 of each word in that order, and pad bytes are dropped. A zero-length packet sends no byte but still completes.
- R3: freeBytes equals the capacity minus 4 for every word held, header words included. A host write while freeBytes is 0 is ignored.
- R4: Command 1 sets the available level from cmdArg, in bytes (reset value: the capacity). txAvail is 1 exactly when freeBytes is at least that level.
- R5: Command 2 sets the start level from cmdArg, in bytes (reset value: the capacity). A packet begins sending once the buffered data bytes (4 per data word) reach that level, or once all of its data words are buffered.
- R6: While macValid is 1 and macReady is 0, macValid stays 1 and macData stays unchanged.
- R7: A packet that finishes pushes status 0x80 into the queue. txComplete is 1 while the queue holds entries. txStatus shows the oldest entry, or 0 when the queue is empty. A statusPop pulse removes the oldest entry, and a pop on an empty queue has no effect.
- R8: A push into a full status queue is dropped, and bit 0x04 is ORed into the newest stored entry.
- R9: If macReady is 1 while a packet is unfinished and no data word is held, the block pushes status 0x90 and stops. Command 4 (enable) alone does not resume it. Command 3 (transmit reset) discards all held words and disables the transmitter, after which command 4 resumes normal operation.
- R10: Command 5 disables the transmitter, and while it is disabled no new packet begins. Command 4 enables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hostWrEn | input | 1 | Host word write strobe |
| hostWrData | input | 32 | Host write word (header or data) |
| cmdValid | input | 1 | Command strobe |
| cmdOp | input | 3 | Command code: 1 avail level, 2 start level, 3 tx reset, 4 enable, 5 disable |
| cmdArg | input | 16 | Command argument in bytes |
| statusPop | input | 1 | Remove the oldest status entry |
| freeBytes | output | FREE_W | Free space in bytes |
| txAvail | output | 1 | Free space is at least the available level |
| txComplete | output | 1 | Status queue is not empty |
| txStatus | output | 8 | Oldest status entry, 0 when empty |
| macValid | output | 1 | Sink byte valid |
| macData | output | 8 | Sink byte |
| macReady | input | 1 | Sink accepts a byte |

## Verification
The bench builds the block with a 16-word store (64 bytes) and a two-entry status queue. With these sizes, a single 60-byte packet fills the store completely, so the write that is ignored when full can be tested. Three quick packets are enough to overflow the status queue. The short store also keeps the start-level and underrun scenarios within a few dozen cycles, with byte-accurate checks of what the sink receives.

// File: rtl/txfifo_pkg.sv
package txfifo_pkg;

  typedef enum logic [2:0] {
    OP_NOP        = 3'd0,
    OP_SET_AVAIL  = 3'd1,
    OP_SET_START  = 3'd2,
    OP_TX_RESET   = 3'd3,
    OP_TX_ENABLE  = 3'd4,
    OP_TX_DISABLE = 3'd5
  } cmdOp_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_WAIT,
    S_SEND,
    S_HALT
  } txState_e;

  // strobes from control to the storage and status queue
  typedef struct packed {
    logic       popWord;
    logic       flush;
    logic       statPush;
    logic [7:0] statCode;
  } ctlStrobe_t;

  localparam logic [7:0] ST_OVERFLOW = 8'h04;
  localparam logic [7:0] ST_UNDERRUN = 8'h10;
  localparam logic [7:0] ST_COMPLETE = 8'h80;

endpackage

// File: rtl/txfifo_store.sv
module txfifo_store
  import txfifo_pkg::*;
#(
  parameter int DEPTH_WORDS = 512,
  localparam int AW = $clog2(DEPTH_WORDS),
  localparam int CW = AW + 1,
  localparam int FREE_W = $clog2(DEPTH_WORDS * 4) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  input  ctlStrobe_t        strobe,
  output logic [31:0]       headWord,
  output logic [CW-1:0]     wordCount,
  output logic [FREE_W-1:0] freeBytes
);

  logic [31:0]   mem [DEPTH_WORDS];
  logic [AW-1:0] wrPtr, rdPtr;
  logic [CW-1:0] count;
  logic          full, doWr, doRd;
  logic [CW-1:0] slack;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH_WORDS - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (count == CW'(DEPTH_WORDS));
  assign doWr  = wrEn && !full && !strobe.flush;
  assign doRd  = strobe.popWord && (count != '0) && !strobe.flush;
  assign slack = CW'(DEPTH_WORDS) - count;

  assign headWord  = mem[rdPtr];
  assign wordCount = count;
  assign freeBytes = FREE_W'({slack, 2'b00});

  always_ff @(posedge clk) begin
    if (doWr) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strobe.flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (doWr) wrPtr <= bump(wrPtr);
      if (doRd) rdPtr <= bump(rdPtr);
      case ({doWr, doRd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/txstat_queue.sv
module txstat_queue
  import txfifo_pkg::*;
#(
  parameter int SDEPTH = 4,
  localparam int SAW = (SDEPTH > 1) ? $clog2(SDEPTH) : 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       push,
  input  logic [7:0] code,
  input  logic       pop,
  output logic [7:0] head,
  output logic       notEmpty
);

  logic [7:0]     slots [SDEPTH];
  logic [SAW-1:0] wrP, rdP, newest;
  logic [SAW:0]   cnt;
  logic           full, doPop, doPush, overflow;

  function automatic logic [SAW-1:0] bump(input logic [SAW-1:0] p);
    return (p == SAW'(SDEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full     = (cnt == (SAW+1)'(SDEPTH));
  assign doPop    = pop && (cnt != '0);
  assign doPush   = push && (!full || doPop);
  assign overflow = push && full && !doPop;
  assign newest   = (wrP == '0) ? SAW'(SDEPTH - 1) : wrP - 1'b1;
  assign notEmpty = (cnt != '0);
  assign head     = notEmpty ? slots[rdP] : 8'h00;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < SDEPTH; i++) slots[i] <= 8'h00;
      wrP <= '0;
      rdP <= '0;
      cnt <= '0;
    end else begin
      if (doPush) begin
        slots[wrP] <= code;
        wrP        <= bump(wrP);
      end
      if (overflow) slots[newest] <= slots[newest] | ST_OVERFLOW;
      if (doPop) rdP <= bump(rdP);
      case ({doPush, doPop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

endmodule

// File: rtl/txfifo_ctrl.sv
module txfifo_ctrl
  import txfifo_pkg::*;
#(
  parameter int DEPTH_WORDS = 512,
  localparam int CW = $clog2(DEPTH_WORDS) + 1,
  localparam int FREE_W = $clog2(DEPTH_WORDS * 4) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [15:0]       cmdArg,
  input  logic [31:0]       headWord,
  input  logic [CW-1:0]     wordCount,
  input  logic [FREE_W-1:0] freeBytes,
  input  logic              macReady,
  output ctlStrobe_t        strobe,
  output logic              macValid,
  output logic [7:0]        macData,
  output logic              txAvail
);

  localparam logic [15:0] CAP_BYTES = 16'(DEPTH_WORDS * 4);

  txState_e    state;
  logic        txOn;
  logic [15:0] availThr, startThr, bytesLeft;
  logic [1:0]  byteIdx;

  logic        resetCmd, haveWord, lastByte, startOk, fire, underrun, takeHdr;
  logic [16:0] needWords;
  logic [17:0] bufBytes;

  assign resetCmd  = cmdValid && (cmdOp == OP_TX_RESET);
  assign haveWord  = (wordCount != '0);
  assign lastByte  = (bytesLeft == 16'd1);
  assign needWords = (17'(bytesLeft) + 17'd3) >> 2;
  assign bufBytes  = 18'({wordCount, 2'b00});
  assign startOk   = (bufBytes >= {2'b00, startThr}) || (17'(wordCount) >= needWords);
  assign takeHdr   = (state == S_IDLE) && txOn && haveWord;

  assign macValid = (state == S_SEND) && haveWord;
  assign macData  = headWord[8*byteIdx +: 8];
  assign fire     = macValid && macReady;
  assign underrun = (state == S_SEND) && !haveWord && macReady;
  assign txAvail  = (17'(freeBytes) >= 17'(availThr));

  always_comb begin
    strobe          = '0;
    strobe.flush    = resetCmd;
    strobe.statCode = ST_COMPLETE;
    if (!resetCmd) begin
      strobe.popWord  = takeHdr || (fire && ((byteIdx == 2'd3) || lastByte));
      strobe.statPush = (takeHdr && (headWord[15:0] == 16'd0))
                        || (fire && lastByte) || underrun;
      if (underrun) strobe.statCode = ST_COMPLETE | ST_UNDERRUN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      txOn      <= 1'b0;
      availThr  <= CAP_BYTES;
      startThr  <= CAP_BYTES;
      bytesLeft <= '0;
      byteIdx   <= '0;
    end else if (resetCmd) begin
      state     <= S_IDLE;
      txOn      <= 1'b0;
      bytesLeft <= '0;
      byteIdx   <= '0;
    end else begin
      if (cmdValid) begin
        case (cmdOp)
          OP_SET_AVAIL:  availThr <= cmdArg;
          OP_SET_START:  startThr <= cmdArg;
          OP_TX_ENABLE:  txOn     <= 1'b1;
          OP_TX_DISABLE: txOn     <= 1'b0;
          default: ;
        endcase
      end
      case (state)
        S_IDLE: begin
          if (takeHdr) begin
            bytesLeft <= headWord[15:0];
            byteIdx   <= '0;
            if (headWord[15:0] != 16'd0) state <= S_WAIT;
          end
        end
        S_WAIT: begin
          if (startOk) state <= S_SEND;
        end
        S_SEND: begin
          if (fire) begin
            bytesLeft <= bytesLeft - 1'b1;
            if (lastByte) begin
              byteIdx <= '0;
              state   <= S_IDLE;
            end else begin
              byteIdx <= byteIdx + 1'b1;
            end
          end else if (underrun) begin
            state <= S_HALT;
            txOn  <= 1'b0;
          end
        end
        default: state <= S_HALT;
      endcase
    end
  end

endmodule

// File: rtl/txfifo_thresh.sv
module txfifo_thresh
  import txfifo_pkg::*;
#(
  parameter int DEPTH_WORDS = 512,
  parameter int STAT_DEPTH = 4,
  localparam int CW = $clog2(DEPTH_WORDS) + 1,
  localparam int FREE_W = $clog2(DEPTH_WORDS * 4) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic [31:0]       hostWrData,
  input  logic              cmdValid,
  input  logic [2:0]        cmdOp,
  input  logic [15:0]       cmdArg,
  input  logic              statusPop,
  output logic [FREE_W-1:0] freeBytes,
  output logic              txAvail,
  output logic              txComplete,
  output logic [7:0]        txStatus,
  output logic              macValid,
  output logic [7:0]        macData,
  input  logic              macReady
);

  ctlStrobe_t    strobe;
  logic [31:0]   headWord;
  logic [CW-1:0] wordCount;

  txfifo_store #(.DEPTH_WORDS(DEPTH_WORDS)) store (
    .clk(clk), .rstN(rstN), .wrEn(hostWrEn), .wrData(hostWrData),
    .strobe(strobe), .headWord(headWord), .wordCount(wordCount),
    .freeBytes(freeBytes)
  );

  txfifo_ctrl #(.DEPTH_WORDS(DEPTH_WORDS)) ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .cmdArg(cmdArg), .headWord(headWord), .wordCount(wordCount),
    .freeBytes(freeBytes), .macReady(macReady), .strobe(strobe),
    .macValid(macValid), .macData(macData), .txAvail(txAvail)
  );

  txstat_queue #(.SDEPTH(STAT_DEPTH)) statQ (
    .clk(clk), .rstN(rstN), .push(strobe.statPush), .code(strobe.statCode),
    .pop(statusPop), .head(txStatus), .notEmpty(txComplete)
  );

endmodule

// File: rtl/txfifo_thresh_chk.sv
module txfifo_thresh_chk #(
  parameter int DEPTH_WORDS = 512,
  parameter int FREE_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic [FREE_W-1:0] freeBytes,
  input logic              macValid,
  input logic              macReady,
  input logic [7:0]        macData,
  input logic              txComplete,
  input logic [7:0]        txStatus,
  input logic              cmdValid,
  input logic [2:0]        cmdOp
);

  localparam int CAP = DEPTH_WORDS * 4;

  // R3
  free_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    (32'(freeBytes) <= CAP) && (freeBytes[1:0] == 2'b00));

  // R6
  sink_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (macValid && !macReady && !(cmdValid && cmdOp == 3'd3))
    |=> (macValid && $stable(macData)));

  // R7
  empty_status_chk: assert property (@(posedge clk) disable iff (!rstN)
    !txComplete |-> (txStatus == 8'h00));

  // R7
  complete_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    txComplete |-> txStatus[7]);

endmodule

bind txfifo_thresh txfifo_thresh_chk #(.DEPTH_WORDS(DEPTH_WORDS), .FREE_W(FREE_W)) chkInst (.*);

// File: tb/txfifo_thresh_test.sv
module txfifo_thresh_test;

  localparam int DW = 16;
  localparam int SD = 2;
  localparam int FW = $clog2(DW * 4) + 1;
  localparam int CAP = DW * 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          hostWrEn = 1'b0;
  logic [31:0]   hostWrData = '0;
  logic          cmdValid = 1'b0;
  logic [2:0]    cmdOp = '0;
  logic [15:0]   cmdArg = '0;
  logic          statusPop = 1'b0;
  logic [FW-1:0] freeBytes;
  logic          txAvail, txComplete, macValid, macReady;
  logic [7:0]    txStatus, macData;

  int total = 0;
  int bad = 0;
  logic [7:0] rxBuf [512];
  int rxCount = 0;

  txfifo_thresh #(.DEPTH_WORDS(DW), .STAT_DEPTH(SD)) uut (.*);

  always #4 clk = ~clk;

  // byte capture one ns before each rising edge
  always begin
    @(negedge clk);
    #3;
    if (macValid && macReady) begin
      rxBuf[rxCount % 512] = macData;
      rxCount++;
    end
  end

  typedef struct packed {
    logic [15:0] len;
    logic [15:0] thr;
    logic [7:0]  stat;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{16'd1,  16'd64, 8'h80},
    '{16'd4,  16'd64, 8'h80},
    '{16'd5,  16'd4,  8'h80},
    '{16'd7,  16'd8,  8'h80},
    '{16'd8,  16'd0,  8'h80},
    '{16'd13, 16'd12, 8'h80}
  };

  function automatic logic [7:0] byteOf(input int seed, input int i);
    return 8'((seed * 29 + i * 7 + 3) & 255);
  endfunction

  function automatic logic [31:0] wordOf(input int seed, input int j);
    return {byteOf(seed, 4*j+3), byteOf(seed, 4*j+2), byteOf(seed, 4*j+1), byteOf(seed, 4*j)};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic issue(input logic [2:0] op, input logic [15:0] arg);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdArg = arg;
    @(negedge clk);
    cmdValid = 1'b0; cmdOp = '0; cmdArg = '0;
  endtask

  task automatic putWord(input logic [31:0] w);
    @(negedge clk);
    hostWrEn = 1'b1; hostWrData = w;
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic writePacket(input int len, input int seed);
    @(negedge clk);
    hostWrEn = 1'b1; hostWrData = 32'(len);
    for (int j = 0; j < (len + 3) / 4; j++) begin
      @(negedge clk);
      hostWrData = wordOf(seed, j);
    end
    @(negedge clk);
    hostWrEn = 1'b0;
  endtask

  task automatic popStatus();
    @(negedge clk);
    statusPop = 1'b1;
    @(negedge clk);
    statusPop = 1'b0;
  endtask

  task automatic waitDone();
    for (int w = 0; w < 300 && !txComplete; w++) @(negedge clk);
  endtask

  task automatic checkBytes(input string req, input int base, input int len, input int seed);
    int miss;
    miss = 0;
    chk(req, 32'(rxCount - base), 32'(len));
    for (int i = 0; i < len; i++)
      if (rxBuf[(base + i) % 512] !== byteOf(seed, i)) miss++;
    chk(req, 32'(miss), 32'd0);
  endtask

  initial begin
    #(8 * 150000);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int base;
    macReady = 1'b1;
    tick(3);
    rstN = 1'b1;
    tick(1);

    // R1 reset state
    chk("R1 freeBytes", 32'(freeBytes), 32'(CAP));
    chk("R1 txAvail", 32'(txAvail), 32'd1);
    chk("R1 txComplete", 32'(txComplete), 32'd0);
    chk("R1 txStatus", 32'(txStatus), 32'd0);
    chk("R1 macValid", 32'(macValid), 32'd0);
    // R1/R10: disabled after reset, nothing leaves
    writePacket(2, 99);
    tick(8);
    chk("R1 disabled no output", 32'(rxCount), 32'd0);
    chk("R10 held while disabled", 32'(freeBytes), 32'(CAP - 8));
    issue(3'd4, 16'd0);
    waitDone();
    chk("R10 enable starts", 32'(txStatus), 32'h80);
    checkBytes("R2 first packet", 0, 2, 99);
    popStatus();

    // R2 R5 R7 table of packets
    for (int k = 0; k < 6; k++) begin
      issue(3'd2, VECS[k].thr);
      base = rxCount;
      writePacket(int'(VECS[k].len), k);
      waitDone();
      chk("R7 status", 32'(txStatus), 32'(VECS[k].stat));
      checkBytes("R2 payload", base, int'(VECS[k].len), k);
      popStatus();
      chk("R7 popped", 32'(txComplete), 32'd0);
    end

    // R3 R4 R10 free space and available level
    issue(3'd5, 16'd0);
    issue(3'd2, 16'd64);
    base = rxCount;
    writePacket(5, 40);
    tick(5);
    chk("R3 free after 3 words", 32'(freeBytes), 32'd52);
    chk("R10 no start while disabled", 32'(macValid), 32'd0);
    issue(3'd1, 16'd56);
    chk("R4 below level", 32'(txAvail), 32'd0);
    issue(3'd1, 16'd52);
    chk("R4 at level", 32'(txAvail), 32'd1);
    issue(3'd4, 16'd0);
    waitDone();
    checkBytes("R2 after enable", base, 5, 40);
    chk("R3 free restored", 32'(freeBytes), 32'(CAP));
    popStatus();

    // R5 R6 R9 start level and underrun
    macReady = 1'b0;
    issue(3'd2, 16'd8);
    base = rxCount;
    putWord(32'd12);
    putWord(wordOf(50, 0));
    tick(6);
    chk("R5 waits below start level", 32'(macValid), 32'd0);
    putWord(wordOf(50, 1));
    tick(3);
    chk("R5 starts at level", 32'(macValid), 32'd1);
    chk("R6 first byte", 32'(macData), 32'(byteOf(50, 0)));
    tick(3);
    chk("R6 byte held", 32'(macData), 32'(byteOf(50, 0)));
    @(negedge clk);
    macReady = 1'b1;
    waitDone();
    chk("R9 underrun status", 32'(txStatus), 32'h90);
    checkBytes("R9 bytes before underrun", base, 8, 50);
    popStatus();
    issue(3'd4, 16'd0);
    putWord(wordOf(50, 2));
    tick(6);
    chk("R9 stays stopped", 32'(macValid), 32'd0);
    chk("R9 no new status", 32'(txComplete), 32'd0);
    issue(3'd3, 16'd0);
    chk("R9 reset flushes", 32'(freeBytes), 32'(CAP));
    issue(3'd4, 16'd0);
    issue(3'd2, 16'd64);
    base = rxCount;
    writePacket(4, 60);
    waitDone();
    chk("R9 resumes", 32'(txStatus), 32'h80);
    checkBytes("R9 resumed payload", base, 4, 60);
    popStatus();

    // R7 R8 status queue overflow and zero length
    writePacket(1, 70);
    tick(12);
    writePacket(1, 71);
    tick(12);
    base = rxCount;
    writePacket(0, 72);
    tick(12);
    chk("R2 zero length sends nothing", 32'(rxCount - base), 32'd0);
    chk("R8 oldest entry", 32'(txStatus), 32'h80);
    popStatus();
    chk("R8 newest flagged", 32'(txStatus), 32'h84);
    popStatus();
    chk("R7 empty", 32'(txComplete), 32'd0);
    popStatus();
    chk("R7 pop on empty", 32'(txStatus), 32'd0);
    chk("R7 pop on empty flag", 32'(txComplete), 32'd0);

    // R3 write while full is ignored
    issue(3'd5, 16'd0);
    writePacket(60, 80);
    tick(2);
    chk("R3 full", 32'(freeBytes), 32'd0);
    chk("R4 not available when full", 32'(txAvail), 32'd0);
    putWord(32'd2);
    chk("R3 still full", 32'(freeBytes), 32'd0);
    base = rxCount;
    issue(3'd4, 16'd0);
    waitDone();
    checkBytes("R2 full packet", base, 60, 80);
    popStatus();
    base = rxCount;
    writePacket(3, 81);
    waitDone();
    checkBytes("R3 ignored write left no trace", base, 3, 81);
    chk("R3 free after drain", 32'(freeBytes), 32'(CAP));
    popStatus();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule